// File: doc/BRIEF.md
# Burst Write Byte-Enable Applier

This block is the memory-side target of a single write stream. A request names a byte address, a length in bytes (8-bit field), a 6-bit tag and two byte-enable masks. The data beats follow on a separate channel. The block works out a byte strobe for each beat and writes that beat into a small internal RAM, touching only the bytes the strobe allows. When the beat carrying the last flag has been taken, the request tag is returned on a completion channel.

The two masks let a burst begin and end on any byte, so a write can cover a run of contiguous bytes narrower than the bus. The first mask shapes the opening beat. The second mask shapes the closing beat. Every beat between them is written in full. A lookup port reads any RAM word combinationally so that the stored result can be observed.

Top module: `burst_be_writer`

## Requirements
- R1: After reset, `req_ready` is 1, `dat_ready` is 0, `done_valid` is 0 and `err_flag` is 0.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. From then on `req_ready` stays low until the completion has been taken. `dat_ready` is high only between request acceptance and acceptance of the beat that carries the last flag.
- R3: The beat count is the byte length divided by the bus width in bytes, rounded down. Beat k is written to word ((req_addr / NB) + k) mod WORDS, so the address advances NB bytes on each accepted beat and wraps at the top of the RAM.
- R4: On beat 0, bit i of `req_be_first` enables byte lane i, which is data bits 8i+7 down to 8i. Lanes whose bit is 0 keep their old contents.
- R5: On the final counted beat of a burst with two or more beats, bit i of `req_be_last` enables byte lane i.
- R6: Every beat strictly between the first beat and the final counted beat writes all byte lanes.
- R7: A burst of exactly one beat is masked by `req_be_first` only. `req_be_last` has no effect on it.
- R8: `done_valid` rises in the cycle after the last-flagged beat is accepted, with `done_tag` equal to the request tag. Both hold steady until `done_ready` is high.
- R9: `err_flag` is set if a beat's last flag does not match whether that beat is the final counted beat, or if a beat's tag differs from the request tag. The flag stays set until reset. The block keeps taking beats until the last flag arrives, and any beat past the counted beats writes no byte.
- R10: `look_data` shows the current contents of RAM word `look_addr`, and reflects a beat written at a clock edge immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Burst length in bytes |
| req_tag | input | 6 | Request tag |
| req_be_first | input | NB | Byte enables for beat 0 |
| req_be_last | input | NB | Byte enables for the final beat of a multi-beat burst |
| dat_valid | input | 1 | Data beat offered |
| dat_ready | output | 1 | Block can take a data beat |
| dat_data | input | DATA_W | Beat payload |
| dat_tag | input | 6 | Tag carried by the beat |
| dat_last | input | 1 | Beat is the final one of its burst |
| done_valid | output | 1 | Completion offered |
| done_ready | input | 1 | Completion taken |
| done_tag | output | 6 | Tag of the completed request |
| err_flag | output | 1 | Sticky protocol error |
| look_addr | input | ADDR_W-log2(NB) | Word index to inspect |
| look_data | output | DATA_W | Contents of that word |

## Verification
The burst patterns used are a single beat with a sparse first mask and a full last mask, which shows whether the last mask leaks onto a one-beat burst. A two-beat burst with disjoint masks tells the two masks apart, and a four-beat burst with gaps between beats shows whether middle beats are written in full. A length that is not a multiple of the bus width and a burst that crosses the top of the RAM test the beat count and the address wrap. Three error cases (last flag too early, last flag too late, and a wrong tag) check that the flag is raised, that it stays set, and that the extra beats write nothing. After every burst the whole RAM is compared against a byte model held in the bench.

// File: rtl/bwba_pkg.sv
package bwba_pkg;

  localparam int LEN_W  = 8;
  localparam int TAG_W  = 6;
  localparam int MAX_NB = 64;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  // beats in a burst: byte length over bus bytes, rounded down
  function automatic logic [LEN_W-1:0] beats_of(input logic [LEN_W-1:0] len_bytes,
                                                input int unsigned shift);
    return len_bytes >> shift;
  endfunction

  // byte lanes enabled for beat `idx` of a burst of `total` beats
  function automatic logic [MAX_NB-1:0] lane_mask(input logic [LEN_W-1:0] idx,
                                                  input logic [LEN_W-1:0] total,
                                                  input logic [MAX_NB-1:0] first_m,
                                                  input logic [MAX_NB-1:0] last_m);
    logic [MAX_NB-1:0] m;
    if (idx == '0)                       m = first_m;
    else if (idx == total - 1'b1)        m = last_m;
    else if (idx < total)                m = '1;
    else                                 m = '0;
    return m;
  endfunction

endpackage

// File: rtl/bwba_seq.sv
module bwba_seq
  import bwba_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NB     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [TAG_W-1:0]      req_tag,
  input  logic [NB-1:0]         req_be_first,
  input  logic [NB-1:0]         req_be_last,
  input  logic                  dat_valid,
  output logic                  dat_ready,
  input  logic [TAG_W-1:0]      dat_tag,
  input  logic                  dat_last,
  output logic                  done_valid,
  input  logic                  done_ready,
  output logic [TAG_W-1:0]      done_tag,
  output logic                  err_flag,
  output logic                  beat_fire,
  output logic [LEN_W-1:0]      beat_idx,
  output logic [LEN_W-1:0]      beat_total,
  output logic [ADDR_W-$clog2(NB)-1:0] beat_word,
  output logic [NB-1:0]         mask_first,
  output logic [NB-1:0]         mask_last
);

  localparam int SH = $clog2(NB);

  seq_state_t          state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    total_q;
  logic [LEN_W-1:0]    idx_q;
  logic [TAG_W-1:0]    tag_q;
  logic [NB-1:0]       fbe_q, lbe_q;
  logic                err_q;

  logic req_fire, done_fire, count_hit, last_bad, tag_bad;

  assign req_ready  = (state_q == ST_IDLE);
  assign dat_ready  = (state_q == ST_DATA);
  assign done_valid = (state_q == ST_DONE);
  assign done_tag   = tag_q;
  assign err_flag   = err_q;

  assign req_fire  = req_valid & req_ready;
  assign beat_fire = dat_valid & dat_ready;
  assign done_fire = done_valid & done_ready;

  assign count_hit = (idx_q == total_q - 1'b1);
  assign last_bad  = beat_fire & (dat_last != count_hit);
  assign tag_bad   = beat_fire & (dat_tag != tag_q);

  assign beat_idx   = idx_q;
  assign beat_total = total_q;
  assign beat_word  = addr_q[ADDR_W-1:SH];
  assign mask_first = fbe_q;
  assign mask_last  = lbe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      total_q <= '0;
      idx_q   <= '0;
      tag_q   <= '0;
      fbe_q   <= '0;
      lbe_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (last_bad || tag_bad) err_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (req_fire) begin
          state_q <= ST_DATA;
          addr_q  <= req_addr;
          total_q <= beats_of(req_len, SH);
          idx_q   <= '0;
          tag_q   <= req_tag;
          fbe_q   <= req_be_first;
          lbe_q   <= req_be_last;
        end
        ST_DATA: if (beat_fire) begin
          addr_q <= addr_q + ADDR_W'(NB);
          if (idx_q != '1) idx_q <= idx_q + 1'b1;
          if (dat_last) state_q <= ST_DONE;
        end
        ST_DONE: if (done_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: at most one channel is open at a time
  p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, dat_ready, done_valid}));

  // R3: each accepted beat moves the address by one bus word
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> addr_q == $past(addr_q) + ADDR_W'(NB));

  // R8: completion follows the last-flagged beat with the request tag
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && dat_last) |=> (done_valid && done_tag == $past(tag_q)));

  // R8: completion held until taken
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> (done_valid && $stable(done_tag)));

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

endmodule

// File: rtl/bwba_lanes.sv
module bwba_lanes
  import bwba_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] idx,
  input  logic [LEN_W-1:0] total,
  input  logic [NB-1:0]    first_m,
  input  logic [NB-1:0]    last_m,
  output logic [NB-1:0]    lanes
);

  logic [MAX_NB-1:0] wide;

  assign wide  = lane_mask(idx, total, MAX_NB'(first_m), MAX_NB'(last_m));
  assign lanes = wide[NB-1:0];

  // R6: beats strictly inside the burst enable every lane
  p_middle_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0 && (9'(idx) + 9'd1) < 9'(total)) |-> (&lanes));

endmodule

// File: rtl/bwba_ram.sv
module bwba_ram #(
  parameter int NB    = 4,
  parameter int WORDS = 64
) (
  input  logic                     clk,
  input  logic [NB-1:0]            we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [8*NB-1:0]          wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [8*NB-1:0]          rdata
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] cells [WORDS];
    always_ff @(posedge clk) begin
      if (we[b]) cells[waddr] <= wdata[8*b +: 8];
    end
    assign rdata[8*b +: 8] = cells[raddr];
  end

endmodule

// File: rtl/burst_be_writer.sv
module burst_be_writer
  import bwba_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int NB     = DATA_W / 8,
  localparam int SH     = $clog2(NB),
  localparam int WORD_W = ADDR_W - SH,
  localparam int WORDS  = 2 ** WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_len,
  input  logic [5:0]        req_tag,
  input  logic [NB-1:0]     req_be_first,
  input  logic [NB-1:0]     req_be_last,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [DATA_W-1:0] dat_data,
  input  logic [5:0]        dat_tag,
  input  logic              dat_last,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [5:0]        done_tag,
  output logic              err_flag,
  input  logic [WORD_W-1:0] look_addr,
  output logic [DATA_W-1:0] look_data
);

  logic              beat_fire;
  logic [LEN_W-1:0]  beat_idx, beat_total;
  logic [WORD_W-1:0] beat_word;
  logic [NB-1:0]     mask_first, mask_last, lanes, wstrb;

  bwba_seq #(.ADDR_W(ADDR_W), .NB(NB)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_tag(req_tag),
    .req_be_first(req_be_first), .req_be_last(req_be_last),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_tag(dat_tag),
    .dat_last(dat_last),
    .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag),
    .err_flag(err_flag),
    .beat_fire(beat_fire), .beat_idx(beat_idx), .beat_total(beat_total),
    .beat_word(beat_word), .mask_first(mask_first), .mask_last(mask_last)
  );

  bwba_lanes #(.NB(NB)) u_lanes (
    .clk(clk), .rst_n(rst_n),
    .idx(beat_idx), .total(beat_total),
    .first_m(mask_first), .last_m(mask_last),
    .lanes(lanes)
  );

  assign wstrb = beat_fire ? lanes : '0;

  bwba_ram #(.NB(NB), .WORDS(WORDS)) u_ram (
    .clk(clk), .we(wstrb), .waddr(beat_word), .wdata(dat_data),
    .raddr(look_addr), .rdata(look_data)
  );

  // R7: a one-beat burst is shaped by the first mask alone
  p_single_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_total == 8'd1 && beat_idx == '0) |-> (wstrb == mask_first));

  // R9: beats past the counted ones touch no byte
  p_beyond_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_idx != '0 && beat_idx >= beat_total) |-> (wstrb == '0));

endmodule

// File: tb/burst_be_writer_bench.sv
`timescale 1ns/1ps
module burst_be_writer_bench;

  localparam int DW = 32, AW = 8, NB = 4, WORDS = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [5:0] req_tag = '0;
  logic [NB-1:0] req_be_first = '0, req_be_last = '0;
  logic dat_valid = 0, dat_ready;
  logic [DW-1:0] dat_data = '0;
  logic [5:0] dat_tag = '0;
  logic dat_last = 0;
  logic done_valid, done_ready = 0;
  logic [5:0] done_tag;
  logic err_flag;
  logic [5:0] look_addr = '0;
  logic [DW-1:0] look_data;

  int total_chk = 0, bad_chk = 0;
  logic [7:0] exp_mem [WORDS*NB];
  bit exp_err = 0;

  always #2 clk = ~clk;

  burst_be_writer u_burst_be_writer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_tag(req_tag),
    .req_be_first(req_be_first), .req_be_last(req_be_last),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .dat_tag(dat_tag), .dat_last(dat_last),
    .done_valid(done_valid), .done_ready(done_ready), .done_tag(done_tag),
    .err_flag(err_flag), .look_addr(look_addr), .look_data(look_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench's own view of which lanes beat k may write
  function automatic logic [NB-1:0] model_lanes(int k, int cnt,
                                                logic [NB-1:0] fm, logic [NB-1:0] lm);
    if (k == 0) return fm;
    if (k < cnt - 1) return '1;
    if (k == cnt - 1) return lm;
    return '0;
  endfunction

  task automatic do_reset();
    rst_n = 0; req_valid = 0; dat_valid = 0; done_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_err = 0;
    @(negedge clk);
  endtask

  task automatic check_mem(input string req);
    int bad_w = -1;
    logic [DW-1:0] got = '0, want = '0;
    for (int w = 0; w < WORDS; w++) begin
      logic [DW-1:0] e;
      look_addr = 6'(w);
      #0.1;
      for (int b = 0; b < NB; b++) e[8*b +: 8] = exp_mem[w*NB + b];
      if (look_data !== e && bad_w < 0) begin
        bad_w = w; got = look_data; want = e;
      end
    end
    check(bad_w < 0, req, $sformatf("ram word %0d", bad_w), 64'(got), 64'(want));
  endtask

  task automatic burst(input logic [AW-1:0] addr, input logic [7:0] len,
                       input logic [5:0] tag, input logic [NB-1:0] fm,
                       input logic [NB-1:0] lm, input int nsend,
                       input bit bad_tag, input int gap, input int hold,
                       input string req);
    int cnt = int'(len) / NB;
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_len = len; req_tag = tag;
    req_be_first = fm; req_be_last = lm;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0 && dat_ready == 1, "R2", "ready pair in data phase",
          {req_ready, dat_ready}, 2'b01);
    for (int k = 0; k < nsend; k++) begin
      logic [NB-1:0] m;
      int word;
      if (gap > 0 && k % 2 == 1) begin
        dat_valid = 0;
        repeat (gap) @(negedge clk);
      end
      dat_valid = 1;
      dat_data = {8'(tag), 8'(k), 8'(addr), 8'(k * 37 + int'(len))};
      dat_tag = bad_tag ? (tag ^ 6'h1) : tag;
      dat_last = (k == nsend - 1);
      while (!dat_ready) @(negedge clk);
      @(posedge clk);
      m = model_lanes(k, cnt, fm, lm);
      word = (int'(addr) / NB + k) % WORDS;
      for (int b = 0; b < NB; b++)
        if (m[b]) exp_mem[word*NB + b] = dat_data[8*b +: 8];
      @(negedge clk);
    end
    dat_valid = 0; dat_last = 0;
    if (nsend != cnt || bad_tag) exp_err = 1;
    check(done_valid == 1 && done_tag == tag, "R8", "done right after last",
          {done_valid, done_tag}, {1'b1, tag});
    check(dat_ready == 0, "R2", "data closed after last", dat_ready, 0);
    repeat (hold) @(negedge clk);
    if (hold > 0)
      check(done_valid == 1 && done_tag == tag && req_ready == 0, "R8",
            "done held while not taken", {req_ready, done_valid, done_tag},
            {1'b0, 1'b1, tag});
    done_ready = 1;
    @(posedge clk);
    @(negedge clk);
    done_ready = 0;
    check(done_valid == 0 && req_ready == 1, "R2", "idle after done taken",
          {done_valid, req_ready}, 2'b01);
    check(err_flag == exp_err, "R9", "error flag", err_flag, exp_err);
    check_mem(req);
  endtask

  task automatic t_reset();
    do_reset();
    check(req_ready == 1 && dat_ready == 0 && done_valid == 0 && err_flag == 0,
          "R1", "reset outputs", {req_ready, dat_ready, done_valid, err_flag}, 4'b1000);
  endtask

  task automatic t_fill();  // R3 R10: full-word fill of the whole RAM
    burst(8'd0,   8'd128, 6'd1, 4'hF, 4'hF, 32, 0, 0, 0, "R10");
    burst(8'd128, 8'd128, 6'd2, 4'hF, 4'hF, 32, 0, 0, 0, "R3");
  endtask

  task automatic t_single();  // R7: last mask must not leak
    burst(8'd20, 8'd4, 6'd5, 4'b0110, 4'b1111, 1, 0, 0, 0, "R7");
  endtask

  task automatic t_two();  // R4 R5: disjoint masks, no middle
    burst(8'd60, 8'd8, 6'd9, 4'b1000, 4'b0001, 2, 0, 0, 0, "R4");
  endtask

  task automatic t_multi();  // R5 R6: middle beats full, with gaps
    burst(8'd40, 8'd16, 6'd12, 4'b1100, 4'b0011, 4, 0, 2, 0, "R6");
  endtask

  task automatic t_wrap();  // R3: crosses top of RAM
    burst(8'd248, 8'd16, 6'd17, 4'b1110, 4'b0111, 4, 0, 0, 0, "R3");
  endtask

  task automatic t_floor();  // R3: 13 bytes -> 3 beats
    burst(8'd100, 8'd13, 6'd21, 4'b0101, 4'b1010, 3, 0, 1, 0, "R3");
  endtask

  task automatic t_hold();  // R8: completion waits for taker
    burst(8'd180, 8'd8, 6'd33, 4'b0011, 4'b1100, 2, 0, 0, 4, "R8");
  endtask

  task automatic t_early();  // R9: last flag two beats early, then sticky
    burst(8'd200, 8'd16, 6'd40, 4'hF, 4'hF, 2, 0, 0, 0, "R9");
    burst(8'd72, 8'd4, 6'd41, 4'b1001, 4'h0, 1, 0, 0, 0, "R9");
    do_reset();
    check(err_flag == 0, "R9", "reset clears error", err_flag, 0);
  endtask

  task automatic t_late();  // R9: extra beats write nothing
    burst(8'd140, 8'd8, 6'd50, 4'b0111, 4'b1110, 4, 0, 0, 0, "R9");
    do_reset();
  endtask

  task automatic t_badtag();  // R9: tag mismatch
    burst(8'd160, 8'd8, 6'd60, 4'hF, 4'hF, 2, 1, 0, 0, "R9");
  endtask

  initial begin
    t_reset();
    t_fill();
    t_single();
    t_two();
    t_multi();
    t_wrap();
    t_floor();
    t_hold();
    t_early();
    t_late();
    t_badtag();
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total_chk++;
    bad_chk++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule